// File: doc/BRIEF.md
# Power-Stage Fault Latch

This block holds a single fault indication for a synchronous buck power stage. An overcurrent comparator bit, an undervoltage comparator bit or an over-temperature condition sets the flag. The over-temperature condition comes from a digitized die temperature with a trip point and a lower release point. While the flag is set, or while any fault is present, a force-off output tells the gate sequencer to keep both switches open.

The flag is only cleared through a handshake with the controller driving the stage. A three-state strap selects which handshake the latch accepts. With the strap at ground, a mid-level (released) PWM input clears the flag. With the strap at supply, PWM low together with the rectifier-enable input low clears it. With the strap left open, only a complete PWM pulse clears it. A complete fault-free PWM pulse, meaning a rise and then a fall with no fault at any point, clears the flag under every strap setting. No clear request takes effect while a fault is still present.

Right after reset the flag reads set, because the supply is still in lockout. It clears by itself at the first fault-free cycle. This self-clear happens only once per reset, so any later undervoltage event needs a normal handshake. All inputs are plain control levels sampled on the clock, so the block has no stream interface and no back-pressure.

Top module: `fault_flag_latch`

## Requirements
- R1: A high `oc_trip` or `uv_trip` sampled on a clock edge makes `fault_flag` read 1 after that edge.
- R2: `force_off` is 1 whenever `fault_flag` is 1 or any fault (overcurrent, undervoltage, over-temperature) is currently present, and 0 otherwise.
- R3: The over-temperature condition is registered. `die_temp` is an unsigned code in whole degrees Celsius. The condition becomes active on the edge where the code is at or above `OT_TRIP` (default 155). It stays active until an edge where the code is at or below `OT_RELEASE` (default 125). Once released, codes between the two points do not re-trip it.
- R4: `pwm_lvl` is encoded as 00 low, 01 high and 10 mid. A falling edge (01 then 00 on consecutive edges) that ends a pulse whose rising edge and every high cycle saw no fault clears the flag on that falling edge, under any strap setting.
- R5: A clear request of any kind has no effect on an edge where a fault is present, and the flag stays 1.
- R6: A fault present at any edge while PWM is high cancels that pulse as a clear. Only a later complete fault-free pulse can clear the flag.
- R7: With `strap_sel` = 00 (ground), `pwm_lvl` = 10 (mid) with no fault clears the flag. PWM low with `sync_en` low does not clear it.
- R8: With `strap_sel` = 01 (supply), `pwm_lvl` = 00 together with `sync_en` = 0 and no fault clears the flag. Mid PWM, or low PWM with `sync_en` = 1, does not clear it.
- R9: With `strap_sel` = 10 (open), and also with 11, only the complete-pulse clear of R4 applies. Mid PWM and low PWM with `sync_en` low leave the flag set.
- R10: During and right after reset `fault_flag` is 1. It clears by itself on the first edge with no fault present, and this self-clear happens only once after each reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_trip | input | 1 | Overcurrent comparator output |
| uv_trip | input | 1 | Undervoltage comparator output (supply outside limits) |
| die_temp | input | TEMP_W | Die temperature code, whole degrees Celsius |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 10 mid |
| sync_en | input | 1 | Synchronous rectifier enable |
| strap_sel | input | 2 | Clear-mode strap: 00 ground, 01 supply, 10/11 open |
| fault_flag | output | 1 | Latched fault flag |
| force_off | output | 1 | Holds both power switches off |

## Verification
The bench builds the block with its default parameters: an 8-bit temperature code, a trip point of 155 and a release point of 125. With these values it can drive codes just below the trip point, inside the hysteresis band and exactly at the release point. These codes show the registered one-cycle lag between `force_off` and the flag, and show that the band does not re-trip. Each strap setting is checked against the clear stimuli it must ignore as well as the one it accepts. PWM pulses are checked both with a fault inserted in the middle and with a fault still present at the falling edge.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

  typedef enum logic [1:0] {
    PWM_LOW  = 2'b00,
    PWM_HIGH = 2'b01,
    PWM_MID  = 2'b10
  } pwm_lvl_e;

  typedef enum logic [1:0] {
    STRAP_GND  = 2'b00,
    STRAP_SUP  = 2'b01,
    STRAP_OPEN = 2'b10
  } strap_e;

endpackage

// File: rtl/ffl_thermal.sv
module ffl_thermal #(
  parameter int TEMP_W     = 8,
  parameter int OT_TRIP    = 155,
  parameter int OT_RELEASE = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              ot_active
);

  localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(OT_TRIP);
  localparam logic [TEMP_W-1:0] REL_CODE  = TEMP_W'(OT_RELEASE);

  logic ot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ot_q <= 1'b0;
    end else if (die_temp >= TRIP_CODE) begin
      ot_q <= 1'b1;
    end else if (die_temp <= REL_CODE) begin
      ot_q <= 1'b0;
    end
  end

  assign ot_active = ot_q;

  AST_OT_HOLDS_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && die_temp > REL_CODE) |=> ot_q); // R3

  AST_OT_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ot_q && die_temp < TRIP_CODE) |=> !ot_q); // R3

endmodule

// File: rtl/ffl_pulse_qual.sv
module ffl_pulse_qual
  import ffl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       fault_now,
  output logic       pulse_clr
);

  logic [1:0] pwm_prev_q;
  logic       armed_q;
  logic       is_high;
  logic       was_high;

  assign is_high  = (pwm_lvl == PWM_HIGH);
  assign was_high = (pwm_prev_q == PWM_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_prev_q <= PWM_LOW;
      armed_q    <= 1'b0;
    end else begin
      pwm_prev_q <= pwm_lvl;
      if (is_high) begin
        armed_q <= was_high ? (armed_q && !fault_now) : !fault_now;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign pulse_clr = was_high && (pwm_lvl == PWM_LOW) && armed_q && !fault_now;

  AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_clr |-> ($past(pwm_lvl) == PWM_HIGH && pwm_lvl == PWM_LOW)); // R4

  AST_FAULT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_now && is_high) |=> !pulse_clr); // R6

endmodule

// File: rtl/ffl_clear_sel.sv
module ffl_clear_sel
  import ffl_pkg::*;
(
  input  logic [1:0] strap_sel,
  input  logic [1:0] pwm_lvl,
  input  logic       sync_en,
  input  logic       pulse_clr,
  output logic       clr_req
);

  logic strap_clr;

  always_comb begin
    case (strap_sel)
      STRAP_GND: strap_clr = (pwm_lvl == PWM_MID);
      STRAP_SUP: strap_clr = (pwm_lvl == PWM_LOW) && !sync_en;
      default:   strap_clr = 1'b0;
    endcase
  end

  assign clr_req = strap_clr || pulse_clr;

endmodule

// File: rtl/fault_flag_latch.sv
module fault_flag_latch
  import ffl_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int OT_TRIP    = 155,
  parameter int OT_RELEASE = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_trip,
  input  logic              uv_trip,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic [1:0]        pwm_lvl,
  input  logic              sync_en,
  input  logic [1:0]        strap_sel,
  output logic              fault_flag,
  output logic              force_off
);

  logic ot_active;
  logic fault_now;
  logic pulse_clr;
  logic clr_req;
  logic flag_q;
  logic boot_q;

  ffl_thermal #(
    .TEMP_W    (TEMP_W),
    .OT_TRIP   (OT_TRIP),
    .OT_RELEASE(OT_RELEASE)
  ) u_thermal (
    .clk      (clk),
    .rst_n    (rst_n),
    .die_temp (die_temp),
    .ot_active(ot_active)
  );

  assign fault_now = oc_trip || uv_trip || ot_active;

  ffl_pulse_qual u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_lvl  (pwm_lvl),
    .fault_now(fault_now),
    .pulse_clr(pulse_clr)
  );

  ffl_clear_sel u_clear (
    .strap_sel(strap_sel),
    .pwm_lvl  (pwm_lvl),
    .sync_en  (sync_en),
    .pulse_clr(pulse_clr),
    .clr_req  (clr_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      boot_q <= 1'b1;
    end else if (fault_now) begin
      flag_q <= 1'b1;
    end else if (boot_q || clr_req) begin
      flag_q <= 1'b0;
      boot_q <= 1'b0;
    end
  end

  assign fault_flag = flag_q;
  assign force_off  = flag_q || fault_now;

  AST_TRIP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip || uv_trip) |=> fault_flag); // R1

  AST_FLAG_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> force_off); // R2

  AST_NO_CLEAR_UNDER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> !$past(fault_now)); // R5

  AST_GND_MID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_sel == STRAP_GND && pwm_lvl == PWM_MID && !fault_now) |=> !fault_flag); // R7

  AST_SUP_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_sel == STRAP_SUP && pwm_lvl == PWM_LOW && !sync_en && !fault_now) |=> !fault_flag); // R8

  AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q); // R10

endmodule

// File: tb/fault_flag_latch_tb.sv
`timescale 1ns/1ps
module fault_flag_latch_tb_top;

  localparam logic [1:0] L = 2'b00, H = 2'b01, M = 2'b10;
  localparam logic [1:0] S_GND = 2'b00, S_SUP = 2'b01, S_OPEN = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc_trip = 1'b0;
  logic       uv_trip = 1'b1;
  logic [7:0] die_temp = 8'd25;
  logic [1:0] pwm_lvl = 2'b00;
  logic       sync_en = 1'b1;
  logic [1:0] strap_sel = 2'b10;
  logic       fault_flag;
  logic       force_off;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  flag;
    logic  frc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  fault_flag_latch dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_trip   (oc_trip),
    .uv_trip   (uv_trip),
    .die_temp  (die_temp),
    .pwm_lvl   (pwm_lvl),
    .sync_en   (sync_en),
    .strap_sel (strap_sel),
    .fault_flag(fault_flag),
    .force_off (force_off)
  );

  task automatic step(input logic oc, input logic uv, input logic [7:0] t,
                      input logic [1:0] p, input logic s, input logic [1:0] st,
                      input logic ef, input logic efo, input string tag);
    exp_t e;
    @(negedge clk);
    oc_trip = oc; uv_trip = uv; die_temp = t;
    pwm_lvl = p; sync_en = s; strap_sel = st;
    e.flag = ef; e.frc = efo; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      checks++;
      if (fault_flag !== cur.flag || force_off !== cur.frc) begin
        errors++;
        $display("FAIL %s: flag=%b force=%b expected flag=%b force=%b",
                 cur.tag, fault_flag, force_off, cur.flag, cur.frc);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fault_flag !== 1'b1 || force_off !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset: flag=%b force=%b expected 1 1", fault_flag, force_off);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(0,1,25,L,1,S_OPEN, 1,1, "R10 held during lockout");
    step(0,0,25,L,1,S_OPEN, 0,0, "R10 self clear after lockout");
    step(1,0,25,L,1,S_OPEN, 1,1, "R1 overcurrent sets flag");
    step(0,0,25,L,1,S_OPEN, 1,1, "R9 idle low holds");
    step(0,0,25,M,1,S_OPEN, 1,1, "R9 mid ignored when open");
    step(0,0,25,L,0,S_OPEN, 1,1, "R9 low with sync low ignored");
    step(0,0,25,H,1,S_OPEN, 1,1, "R4 rising edge");
    step(0,0,25,L,1,S_OPEN, 0,0, "R4 falling edge clears");

    step(1,0,25,L,1,S_OPEN, 1,1, "R1 overcurrent again");
    step(0,0,25,H,1,S_OPEN, 1,1, "R6 pulse start");
    step(1,0,25,H,1,S_OPEN, 1,1, "R6 fault inside pulse");
    step(0,0,25,H,1,S_OPEN, 1,1, "R6 pulse continues");
    step(0,0,25,L,1,S_OPEN, 1,1, "R6 cancelled pulse no clear");
    step(0,0,25,H,1,S_OPEN, 1,1, "R6 next pulse start");
    step(0,0,25,L,1,S_OPEN, 0,0, "R6 next clean pulse clears");

    step(1,0,25,L,1,S_GND, 1,1, "R1 set for ground mode");
    step(1,0,25,M,1,S_GND, 1,1, "R5 mid with fault present");
    step(0,0,25,L,0,S_GND, 1,1, "R7 low sync low ignored");
    step(0,0,25,M,1,S_GND, 0,0, "R7 mid clears");

    step(0,1,25,M,1,S_SUP, 1,1, "R1 undervoltage sets flag");
    step(0,0,25,M,1,S_SUP, 1,1, "R8 mid ignored; R10 no second self clear");
    step(0,0,25,L,1,S_SUP, 1,1, "R8 sync high holds");
    step(0,0,25,L,0,S_SUP, 0,0, "R8 low with sync low clears");
    step(1,0,25,L,1,S_SUP, 1,1, "R1 set in supply mode");
    step(0,0,25,H,1,S_SUP, 1,1, "R4 rising in supply mode");
    step(0,0,25,L,1,S_SUP, 0,0, "R4 pulse clears in supply mode");

    step(0,0,155,L,1,S_OPEN, 0,1, "R3 trip forces off before flag");
    step(0,0,140,L,1,S_OPEN, 1,1, "R3 flag follows trip");
    step(0,0,126,H,1,S_OPEN, 1,1, "R3 band holds");
    step(0,0,126,L,1,S_OPEN, 1,1, "R5 pulse under overtemp no clear");
    step(0,0,125,L,1,S_OPEN, 1,1, "R3 release point");
    step(0,0,125,H,1,S_OPEN, 1,1, "R4 rising after release");
    step(0,0,154,L,1,S_OPEN, 0,0, "R3 band no retrip; R4 clears");
    step(0,0,154,L,1,S_OPEN, 0,0, "R3 below trip stays clear");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule